// File: doc/BRIEF.md
# Reed-Solomon Symbol Error Correction Applier

This block sits after a Reed-Solomon decoder that works on 12-bit symbols and writes the decoder's corrections back into a page buffer. The buffer holds 2048 data bytes, with the spare-area bytes at the addresses directly after them (spare byte k sits at buffer address 2048 + k). The codeword packs its 12-bit symbols across byte boundaries, and its first symbol carries only eight bits. Because of this, one error can touch one byte or two, and the way a pattern is split depends on whether its symbol position is odd or even.

A caller gives an error count and up to four (position, pattern) pairs and pulses `start`. The block checks every pair in use. If any pair is illegal, it reports failure and does not touch the buffer. Otherwise it applies each correction as a read-modify-write XOR through the buffer's read port and write port, one byte at a time. It then raises `done` for one cycle, with `fail` and `fixed_count` valid.

The controller is a single state machine with these states:
- IDLE: waits for `start` and captures the inputs (IDLE→SCAN).
- SCAN: validates all pairs at once. It goes to FINISH when any pair is bad or the count is zero, and to PICK otherwise.
- PICK: registers the byte operations of the current pair (PICK→READ).
- READ: issues the buffer read (READ→WRITE).
- WRITE: writes the XORed byte. It goes to READ when the pair's second byte is still due, to PICK for the next pair, and to FINISH after the last pair.
- FINISH: pulses `done` (FINISH→IDLE).

Top module: `rs_sym_fixer`

## Requirements
- R1: While reset is held and in the first cycle after it, `done`, `fail`, `buf_rd_en` and `buf_wr_en` are low and `fixed_count` is 0.
- R2: A used pair whose position is above 1374 makes the page fail: `fail` is 1, `fixed_count` is 0 and no buffer byte changes.
- R3: Position 0 touches only buffer byte 0. If the pattern bits 11:8 are all zero, byte 0 is XORed with pattern bits 7:0. Otherwise the page fails and the buffer is left unchanged.
- R4: For an odd position p with b = floor(3p/2), byte b is XORed with pattern bits 11:4, and byte b+1 is XORed with pattern bits 3:0 placed in bits 7:4.
- R5: For an even nonzero position p with b = 3p/2, byte b-1 is XORed with pattern bits 11:8 in bits 3:0, and byte b is XORed with pattern bits 7:0. Two pairs that touch the same byte both take effect.
- R6: Position 1365 splits across the two areas: data byte 2047 takes pattern bits 11:4, and spare byte 0 (address 2048) takes bits 3:0 in its upper nibble. Positions 1366 to 1374 land in the spare area by the same odd/even rule.
- R7: An error count above four fails the page with no buffer change. Pairs at indices at or above the given count are ignored, even if they are illegal.
- R8: On success `fail` is 0 and `fixed_count` equals the error count (0 to 4).
- R9: On success, `done` rises exactly 2 + Σ(1 + 2·bytes_i) cycles after the `start` edge, where bytes_i is 1 for position 0 and 2 otherwise. It is a single-cycle pulse. Each byte update is a read cycle followed by a write cycle to the same address.
- R10: On failure, `done` rises 2 cycles after the `start` edge, and no read or write is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a page correction (taken in IDLE) |
| err_num | input | 3 | Number of error pairs supplied |
| err_pos | input | 44 | Four 11-bit symbol positions, pair i at bits [11i +: 11] |
| err_pat | input | 48 | Four 12-bit error patterns, pair i at bits [12i +: 12] |
| buf_rd_en | output | 1 | Buffer read request |
| buf_rd_addr | output | 12 | Buffer read address |
| buf_rd_data | input | 8 | Read data, returned one cycle after the request |
| buf_wr_en | output | 1 | Buffer write strobe |
| buf_wr_addr | output | 12 | Buffer write address |
| buf_wr_data | output | 8 | Buffer write data |
| done | output | 1 | One-cycle completion pulse |
| fail | output | 1 | Page uncorrectable; held until the next start |
| fixed_count | output | 3 | Corrected symbol count; held until the next start |

## Verification
The bench predicts when each result appears. A rejected page must finish two cycles after the start edge. An accepted page must finish after 2 + Σ(1 + 2·bytes_i) cycles, and `done` must be low again one cycle later. After raising `start`, the bench counts falling edges until `done` is seen and compares the count with this formula. It then reads `fail` and `fixed_count` in that same cycle, when every write has already landed, and compares the whole buffer model with a golden copy.

// File: rtl/rsfix_pkg.sv
package rsfix_pkg;

    localparam int SYM_W       = 12;
    localparam int BYTE_W      = 8;
    localparam int DATA_BYTES  = 2048;
    localparam int SPARE_BYTES = 64;
    localparam int BUF_BYTES   = DATA_BYTES + SPARE_BYTES;
    localparam int ADDR_W      = $clog2(BUF_BYTES);
    localparam int POS_W       = 11;

    typedef logic [ADDR_W-1:0] baddr_t;

    typedef struct packed {
        logic              legal;
        logic              pair;
        baddr_t            a_lo;
        logic [BYTE_W-1:0] m_lo;
        baddr_t            a_hi;
        logic [BYTE_W-1:0] m_hi;
    } sym_ops_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SCAN,
        ST_PICK,
        ST_READ,
        ST_WRITE,
        ST_FINISH
    } fix_state_t;

endpackage

// File: rtl/rsfix_locate.sv
module rsfix_locate
    import rsfix_pkg::*;
#(
    parameter int MAX_POS = 1374
) (
    input  logic [POS_W-1:0] pos,
    input  logic [SYM_W-1:0] pat,
    output sym_ops_t         ops
);

    localparam int TRI_W = POS_W + 2;

    logic [TRI_W-1:0] triple;
    baddr_t           base;
    logic             in_range;

    // 3p computed as 2p + p, then halved to get the byte offset
    assign triple   = {1'b0, pos, 1'b0} + {2'b00, pos};
    assign base     = baddr_t'(triple >> 1);
    assign in_range = (int'(pos) <= MAX_POS);

    always_comb begin
        ops = '0;
        if (pos == '0) begin
            // First symbol is eight bits wide: upper nibble must be clear
            ops.legal = in_range && (pat[11:8] == 4'h0);
            ops.pair  = 1'b0;
            ops.a_lo  = '0;
            ops.m_lo  = pat[7:0];
        end else if (pos[0]) begin
            ops.legal = in_range;
            ops.pair  = 1'b1;
            ops.a_lo  = base;
            ops.m_lo  = pat[11:4];
            ops.a_hi  = base + baddr_t'(1);
            ops.m_hi  = {pat[3:0], 4'h0};
        end else begin
            ops.legal = in_range;
            ops.pair  = 1'b1;
            ops.a_lo  = base - baddr_t'(1);
            ops.m_lo  = {4'h0, pat[11:8]};
            ops.a_hi  = base;
            ops.m_hi  = pat[7:0];
        end
    end

endmodule

// File: rtl/rsfix_seq.sv
module rsfix_seq
    import rsfix_pkg::*;
#(
    parameter int MAX_ERR = 4,
    parameter int NUM_W   = 3
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       start,
    input  logic [NUM_W-1:0]           err_num,
    input  sym_ops_t [MAX_ERR-1:0]     ops_all,
    output logic                       capture,
    output logic                       rd_en,
    output baddr_t                     rd_addr,
    input  logic [BYTE_W-1:0]          rd_data,
    output logic                       wr_en,
    output baddr_t                     wr_addr,
    output logic [BYTE_W-1:0]          wr_data,
    output logic                       done,
    output logic                       fail,
    output logic [NUM_W-1:0]           fixed_count
);

    localparam int IDX_W = (MAX_ERR > 1) ? $clog2(MAX_ERR) : 1;

    fix_state_t         state, state_nx;
    logic [NUM_W-1:0]   num_q;
    logic [IDX_W-1:0]   idx_q;
    logic               hi_q;
    sym_ops_t           cur_q;
    logic               fail_q;
    logic [NUM_W-1:0]   cnt_q;
    logic               bad_any;
    logic               last_entry;
    logic               more_bytes;
    logic [BYTE_W-1:0]  cur_mask;

    // Validate every pair in use at once; unused slots are ignored
    always_comb begin
        bad_any = (num_q > NUM_W'(MAX_ERR));
        for (int i = 0; i < MAX_ERR; i++) begin
            if ((NUM_W'(i) < num_q) && !ops_all[i].legal) begin
                bad_any = 1'b1;
            end
        end
    end

    assign last_entry = ((NUM_W'(idx_q) + NUM_W'(1)) == num_q);
    assign more_bytes = cur_q.pair && !hi_q;
    assign cur_mask   = hi_q ? cur_q.m_hi : cur_q.m_lo;

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:   if (start) state_nx = ST_SCAN;
            ST_SCAN:   state_nx = (bad_any || (num_q == '0)) ? ST_FINISH : ST_PICK;
            ST_PICK:   state_nx = ST_READ;
            ST_READ:   state_nx = ST_WRITE;
            ST_WRITE: begin
                if (more_bytes)      state_nx = ST_READ;
                else if (last_entry) state_nx = ST_FINISH;
                else                 state_nx = ST_PICK;
            end
            ST_FINISH: state_nx = ST_IDLE;
            default:   state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            num_q  <= '0;
            idx_q  <= '0;
            hi_q   <= 1'b0;
            cur_q  <= '0;
            fail_q <= 1'b0;
            cnt_q  <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (start) begin
                        num_q  <= err_num;
                        idx_q  <= '0;
                        fail_q <= 1'b0;
                        cnt_q  <= '0;
                    end
                end
                ST_SCAN: begin
                    fail_q <= bad_any;
                    cnt_q  <= bad_any ? '0 : num_q;
                end
                ST_PICK: begin
                    cur_q <= ops_all[idx_q];
                    hi_q  <= 1'b0;
                end
                ST_READ: begin
                end
                ST_WRITE: begin
                    if (more_bytes) hi_q  <= 1'b1;
                    else            idx_q <= idx_q + IDX_W'(1);
                end
                ST_FINISH: begin
                end
                default: begin
                end
            endcase
        end
    end

    assign capture     = (state == ST_IDLE) && start;
    assign rd_en       = (state == ST_READ);
    assign rd_addr     = hi_q ? cur_q.a_hi : cur_q.a_lo;
    assign wr_en       = (state == ST_WRITE);
    assign wr_addr     = rd_addr;
    assign wr_data     = rd_data ^ cur_mask;
    assign done        = (state == ST_FINISH);
    assign fail        = fail_q;
    assign fixed_count = cnt_q;

    p_rd_wr_exclusive_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_en && wr_en));

    p_write_follows_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> $past(rd_en));

    p_write_same_addr_r9: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (wr_addr == $past(rd_addr)));

    p_fail_blocks_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        fail |-> !wr_en);

    p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_count_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (fixed_count <= NUM_W'(MAX_ERR)));

    p_addr_in_buffer_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (int'(wr_addr) < BUF_BYTES));

    p_fail_no_count_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (done && fail) |-> (fixed_count == '0));

endmodule

// File: rtl/rs_sym_fixer.sv
module rs_sym_fixer
    import rsfix_pkg::*;
#(
    parameter int MAX_ERR = 4,
    parameter int MAX_POS = 1374,
    parameter int NUM_W   = $clog2(MAX_ERR + 1)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       start,
    input  logic [NUM_W-1:0]           err_num,
    input  logic [MAX_ERR*POS_W-1:0]   err_pos,
    input  logic [MAX_ERR*SYM_W-1:0]   err_pat,
    output logic                       buf_rd_en,
    output logic [ADDR_W-1:0]          buf_rd_addr,
    input  logic [BYTE_W-1:0]          buf_rd_data,
    output logic                       buf_wr_en,
    output logic [ADDR_W-1:0]          buf_wr_addr,
    output logic [BYTE_W-1:0]          buf_wr_data,
    output logic                       done,
    output logic                       fail,
    output logic [NUM_W-1:0]           fixed_count
);

    logic [MAX_ERR*POS_W-1:0] pos_q;
    logic [MAX_ERR*SYM_W-1:0] pat_q;
    sym_ops_t [MAX_ERR-1:0]   ops_all;
    logic                     capture;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pos_q <= '0;
            pat_q <= '0;
        end else if (capture) begin
            pos_q <= err_pos;
            pat_q <= err_pat;
        end
    end

    for (genvar g = 0; g < MAX_ERR; g++) begin : g_loc
        rsfix_locate #(
            .MAX_POS (MAX_POS)
        ) u_loc (
            .pos (pos_q[g*POS_W +: POS_W]),
            .pat (pat_q[g*SYM_W +: SYM_W]),
            .ops (ops_all[g])
        );
    end

    rsfix_seq #(
        .MAX_ERR (MAX_ERR),
        .NUM_W   (NUM_W)
    ) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .err_num     (err_num),
        .ops_all     (ops_all),
        .capture     (capture),
        .rd_en       (buf_rd_en),
        .rd_addr     (buf_rd_addr),
        .rd_data     (buf_rd_data),
        .wr_en       (buf_wr_en),
        .wr_addr     (buf_wr_addr),
        .wr_data     (buf_wr_data),
        .done        (done),
        .fail        (fail),
        .fixed_count (fixed_count)
    );

endmodule

// File: tb/test_rs_sym_fixer.sv
module test_rs_sym_fixer;
    import rsfix_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int NE         = 4;
    localparam int NW         = 3;
    localparam int LIMIT      = 1374;

    logic                  clk = 1'b0;
    logic                  rst_n = 1'b0;
    logic                  start = 1'b0;
    logic                  init_req = 1'b0;
    logic [NW-1:0]         err_num = '0;
    logic [NE*POS_W-1:0]   err_pos = '0;
    logic [NE*SYM_W-1:0]   err_pat = '0;
    logic                  buf_rd_en, buf_wr_en;
    logic [ADDR_W-1:0]     buf_rd_addr, buf_wr_addr;
    logic [7:0]            buf_rd_data, buf_wr_data;
    logic                  done, fail;
    logic [NW-1:0]         fixed_count;

    logic [7:0] mem  [BUF_BYTES];
    logic [7:0] gold [BUF_BYTES];

    int vectors = 0;
    int miscompares = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        if (init_req) begin
            for (int i = 0; i < BUF_BYTES; i++) mem[i] <= 8'($urandom);
        end else if (buf_wr_en) begin
            mem[buf_wr_addr] <= buf_wr_data;
        end
        buf_rd_data <= mem[buf_rd_addr];
    end

    rs_sym_fixer i_rs_sym_fixer (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .err_num     (err_num),
        .err_pos     (err_pos),
        .err_pat     (err_pat),
        .buf_rd_en   (buf_rd_en),
        .buf_rd_addr (buf_rd_addr),
        .buf_rd_data (buf_rd_data),
        .buf_wr_en   (buf_wr_en),
        .buf_wr_addr (buf_wr_addr),
        .buf_wr_data (buf_wr_data),
        .done        (done),
        .fail        (fail),
        .fixed_count (fixed_count)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        vectors++;
        if (!ok) begin
            miscompares++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Golden application of one correction, written from the mapping rules
    task automatic gold_apply(input int p, input int t);
        int b;
        b = (3 * p) / 2;
        if (p == 0) begin
            gold[0] = gold[0] ^ 8'(t & 255);
        end else if (p % 2 == 1) begin
            gold[b]     = gold[b]     ^ 8'((t >> 4) & 255);
            gold[b + 1] = gold[b + 1] ^ 8'((t & 15) << 4);
        end else begin
            gold[b - 1] = gold[b - 1] ^ 8'((t >> 8) & 15);
            gold[b]     = gold[b]     ^ 8'(t & 255);
        end
    endtask

    task automatic run_case(input int n, input int pa[4], input int ta[4], input string req);
        bit exp_fail;
        int lat, cyc, bad, first_bad;
        exp_fail = (n > NE);
        for (int i = 0; i < n && i < NE; i++) begin
            if (pa[i] > LIMIT || (pa[i] == 0 && ta[i] > 255)) exp_fail = 1'b1;
        end
        for (int i = 0; i < BUF_BYTES; i++) gold[i] = mem[i];
        lat = 2;
        if (!exp_fail) begin
            for (int i = 0; i < n; i++) begin
                gold_apply(pa[i], ta[i]);
                lat += (pa[i] == 0) ? 3 : 5;
            end
        end
        err_num = NW'(n);
        for (int i = 0; i < NE; i++) begin
            err_pos[i*POS_W +: POS_W] = POS_W'(pa[i]);
            err_pat[i*SYM_W +: SYM_W] = SYM_W'(ta[i]);
        end
        start = 1'b1;
        cyc = 0;
        do begin
            @(negedge clk);
            start = 1'b0;
            cyc++;
        end while (!done && cyc < 200);
        chk(cyc == lat, exp_fail ? "R10" : "R9", "done latency", cyc, lat);
        chk(fail == exp_fail, req, "fail flag", int'(fail), int'(exp_fail));
        chk(int'(fixed_count) == (exp_fail ? 0 : n), "R8", "fixed_count",
            int'(fixed_count), exp_fail ? 0 : n);
        bad = 0;
        first_bad = -1;
        for (int i = 0; i < BUF_BYTES; i++) begin
            if (mem[i] !== gold[i]) begin
                bad++;
                if (first_bad < 0) first_bad = i;
            end
        end
        if (bad != 0)
            chk(1'b0, req, $sformatf("buffer byte %0d", first_bad),
                int'(mem[first_bad]), int'(gold[first_bad]));
        else
            chk(1'b1, req, "buffer", 0, 0);
        @(negedge clk);
        chk(!done, "R9", "done pulse width", int'(done), 0);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        miscompares++;
        vectors++;
        $display("FAIL R9 watchdog expired: actual=%0d expected=%0d", 1, 0);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        int ps[4];
        int ts[4];
        int n;
        void'($urandom(32'd7321));
        init_req = 1'b1;
        repeat (3) @(negedge clk);
        init_req = 1'b0;
        // R1: reset state
        chk(!done && !fail && !buf_rd_en && !buf_wr_en && fixed_count == 0,
            "R1", "outputs in reset", int'(done) + int'(fail) + int'(buf_wr_en), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!done && !fail && !buf_rd_en && !buf_wr_en && fixed_count == 0,
            "R1", "outputs after reset", int'(done) + int'(fail) + int'(buf_rd_en), 0);

        run_case(0, '{0, 0, 0, 0},            '{0, 0, 0, 0},               "R8");
        run_case(1, '{0, 0, 0, 0},            '{'h0A5, 0, 0, 0},           "R3");
        run_case(1, '{0, 0, 0, 0},            '{'h1A5, 0, 0, 0},           "R3");
        run_case(1, '{7, 0, 0, 0},            '{'hB3C, 0, 0, 0},           "R4");
        run_case(1, '{10, 0, 0, 0},           '{'h9E1, 0, 0, 0},           "R5");
        run_case(2, '{1, 2, 0, 0},            '{'hFFF, 'h5A5, 0, 0},       "R5");
        run_case(1, '{1365, 0, 0, 0},         '{'hC3D, 0, 0, 0},           "R6");
        run_case(2, '{1366, 1374, 0, 0},      '{'h123, 'h876, 0, 0},       "R6");
        run_case(1, '{1375, 0, 0, 0},         '{'h111, 0, 0, 0},           "R2");
        run_case(3, '{5, 2047, 9, 0},         '{'h222, 'h333, 'h444, 0},   "R2");
        run_case(5, '{3, 4, 5, 6},            '{1, 2, 3, 4},               "R7");
        run_case(2, '{20, 21, 2000, 0},       '{'hABC, 'hDEF, 'h777, 'h100}, "R7");
        run_case(4, '{0, 1365, 1374, 600},    '{'h0FF, 'hFFF, 'hFFF, 'hFFF}, "R8");

        for (int v = 0; v < 300; v++) begin
            n = int'($urandom_range(0, 4));
            for (int i = 0; i < 4; i++) begin
                ps[i] = int'($urandom_range(0, LIMIT));
                if ($urandom_range(0, 19) == 0) ps[i] = int'($urandom_range(LIMIT + 1, 2047));
                if ($urandom_range(0, 9) == 0) ps[i] = 0;
                ts[i] = int'($urandom_range(0, 4095));
                if (ps[i] == 0 && $urandom_range(0, 3) != 0) ts[i] = ts[i] & 255;
            end
            if ($urandom_range(0, 29) == 0) n = int'($urandom_range(5, 7));
            run_case(n, ps, ts, "R8");
        end

        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule